// File: doc/BRIEF.md
# Paged Indirect Register Access Sequencer

This block sits on the master side of a management bus. It takes one request for a wide switch register and turns it into a short run of 16-bit register transactions. All of them go to one fixed management PHY address. A request names a page, a register offset inside that page, a width of 8, 16, 32, 48 or 64 bits, a direction, and up to 64 bits of write data. The block returns a one-cycle completion pulse, an error flag and, for reads, the assembled data.

The far side of the block sees a plain register port that carries one 16-bit access at a time. The block raises a request, holds the address and data steady until the acknowledge arrives, and samples the read word and error flag on that acknowledge.

The block keeps the last page it programmed, so it writes the page register only when the page changes. It starts the operation with a command write. It then polls the command register for completion, with a settable idle gap between polls and a fixed limit on the number of polls. Data moves through four consecutive 16-bit data registers.

Top module: `paged_reg_seq`

## Requirements
- R1: Every downstream transaction carries the PHY address given by parameter PHY_ADDR (default 30) on `mg_phy`.
- R2: The page register (offset 0x10) is written with the page in bits 15:8 and bit 0 set, only when the requested page differs from the cached page. After reset the cached page is 0xFF. A page write that is acknowledged without error loads the cache.
- R3: The command register (offset 0x11) is written with the register offset in bits 15:8, bit 0 set for a write, bit 1 set for a read, and all other bits zero.
- R4: The `req_width` code selects the word count: 0 (8 bit) gives 1 word, 1 (16 bit) gives 1, 2 (32 bit) gives 2, 3 (48 bit) gives 3, and 4 (64 bit) gives 4. Word i moves through data register 0x18+i, with the least significant word at 0x18. An 8-bit write sends only the low byte, with the upper byte zero.
- R5: A write request sends every data word first, then the page write if one is needed, then the command.
- R6: After the command, the block reads register 0x11 until bits 1:0 are both clear. If they are still set on the fifth read, the request ends with `err` set and no data is read.
- R7: Between two poll reads the downstream port stays idle for at least `poll_gap` cycles.
- R8: For a read, the data words are read only after completion and are assembled least significant word first. An 8-bit read keeps only the low byte. Bits above the request width read as zero.
- R9: A downstream error ends the request at once: no further transaction is issued, and `done` is raised with `err`.
- R10: `req_ready` is high only while the block is idle and never together with `mg_req`. `done` is a single-cycle pulse. An unacknowledged downstream request holds its address, direction and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_page | input | 8 | Switch register page |
| req_offs | input | 8 | Register offset inside the page |
| req_width | input | 3 | Width code: 0=8, 1=16, 2=32, 3=48, 4=64 bits |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data, least significant bits first |
| poll_gap | input | DLY_W | Idle cycles between poll reads |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request failed (valid with `done`) |
| rdata | output | 64 | Assembled read data, held until the next request |
| mg_req | output | 1 | Downstream transaction request |
| mg_we | output | 1 | Downstream direction, 1 = write |
| mg_phy | output | 5 | Downstream PHY address |
| mg_reg | output | 5 | Downstream register address |
| mg_wdata | output | 16 | Downstream write word |
| mg_ack | input | 1 | Downstream acknowledge, one cycle |
| mg_rdata | input | 16 | Downstream read word, valid with `mg_ack` |
| mg_err | input | 1 | Downstream error, valid with `mg_ack` |

## Verification
The bench sends requests in both directions across all five widths. It mixes pages from a small set, so that page hits and page changes both occur, and it uses busy counts from zero to four, random acknowledge latency and random poll gaps.

- The page mix tests whether the page cache is used or bypassed.
- The widths test word counts, word placement and the 8-bit masking.
- The busy counts show whether polling stops on the first clear read.

Directed cases cover the first request after reset, a fifth busy read (timeout), and injected errors on a page write, a data write, a poll and a data read. The error cases confirm that the request aborts at once. The page-write error also shows that a failed page write leaves the cache unchanged, so the next request writes the page again.

// File: rtl/prs_pkg.sv
package prs_pkg;

    typedef enum logic [2:0] {
        WID_8  = 3'd0,
        WID_16 = 3'd1,
        WID_32 = 3'd2,
        WID_48 = 3'd3,
        WID_64 = 3'd4
    } width_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WDATA,
        S_PAGE,
        S_CMD,
        S_POLL,
        S_WAIT,
        S_RDATA
    } state_e;

    localparam logic [4:0] MREG_PAGE  = 5'h10;
    localparam logic [4:0] MREG_CMD   = 5'h11;
    localparam logic [4:0] MREG_DATA0 = 5'h18;

    typedef struct packed {
        logic [7:0]  page;
        logic [7:0]  offs;
        width_e      width;
        logic        write;
        logic [63:0] wdata;
    } req_t;

    function automatic logic [2:0] word_count(width_e w);
        case (w)
            WID_8, WID_16: return 3'd1;
            WID_32:        return 3'd2;
            WID_48:        return 3'd3;
            default:       return 3'd4;
        endcase
    endfunction

    function automatic logic [15:0] pick_word(logic [63:0] d, logic [1:0] i, width_e w);
        logic [15:0] x;
        x = d[{i, 4'b0000} +: 16];
        if (w == WID_8) x[15:8] = 8'h00;
        return x;
    endfunction

    function automatic logic [63:0] width_mask(width_e w);
        case (w)
            WID_8:   return 64'h0000_0000_0000_00FF;
            WID_16:  return 64'h0000_0000_0000_FFFF;
            WID_32:  return 64'h0000_0000_FFFF_FFFF;
            WID_48:  return 64'h0000_FFFF_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/prs_page_cache.sv
module prs_page_cache #(
    parameter int          PAGE_W     = 8,
    parameter logic [7:0]  RESET_PAGE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [PAGE_W-1:0] ld_page,
    output logic [PAGE_W-1:0] cur_page
);
    always_ff @(posedge clk) begin
        if (rst)
            cur_page <= PAGE_W'(RESET_PAGE);
        else if (ld)
            cur_page <= ld_page;
    end
endmodule

// File: rtl/prs_poll_ctrl.sv
module prs_poll_ctrl #(
    parameter int MAX_POLLS = 5,
    parameter int DLY_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             miss,
    input  logic [DLY_W-1:0] gap,
    output logic             last_try,
    output logic             wait_over
);
    localparam int POLL_W = $clog2(MAX_POLLS + 1);

    logic [POLL_W-1:0] cnt;
    logic [DLY_W-1:0]  dly;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (miss)
            cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            dly <= '0;
        else if (miss)
            dly <= gap;
        else if (dly != '0)
            dly <= dly - 1'b1;
    end

    assign last_try  = (cnt == POLL_W'(MAX_POLLS - 1));
    assign wait_over = (dly == '0);
endmodule

// File: rtl/prs_word_buf.sv
module prs_word_buf
    import prs_pkg::*;
#(
    parameter int NWORDS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        ld,
    input  logic [1:0]  idx,
    input  logic [15:0] word,
    input  width_e      width,
    output logic [63:0] rdata
);
    logic [NWORDS*16-1:0] flat;

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || clr)
                flat[g*16 +: 16] <= '0;
            else if (ld && idx == 2'(g))
                flat[g*16 +: 16] <= word;
        end
    end

    assign rdata = 64'(flat) & width_mask(width);
endmodule

// File: rtl/paged_reg_seq.sv
module paged_reg_seq
    import prs_pkg::*;
#(
    parameter int PHY_ADDR  = 30,
    parameter int MAX_POLLS = 5,
    parameter int DLY_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_page,
    input  logic [7:0]       req_offs,
    input  logic [2:0]       req_width,
    input  logic             req_write,
    input  logic [63:0]      req_wdata,
    input  logic [DLY_W-1:0] poll_gap,
    output logic             done,
    output logic             err,
    output logic [63:0]      rdata,
    output logic             mg_req,
    output logic             mg_we,
    output logic [4:0]       mg_phy,
    output logic [4:0]       mg_reg,
    output logic [15:0]      mg_wdata,
    input  logic             mg_ack,
    input  logic [15:0]      mg_rdata,
    input  logic             mg_err
);
    state_e     state;
    req_t       rq;
    logic [1:0] idx;
    logic [7:0] cur_page;
    logic       last_try, wait_over;
    logic       accept, cache_ld, poll_clr, poll_miss, buf_ld;
    logic       last_word, page_new_in, page_new_q, busy;
    logic [2:0] nw;

    assign accept      = (state == S_IDLE) && req_valid;
    assign nw          = word_count(rq.width);
    assign last_word   = ({1'b0, idx} == nw - 3'd1);
    assign page_new_in = (req_page != cur_page);
    assign page_new_q  = (rq.page != cur_page);
    assign busy        = (mg_rdata[1:0] != 2'b00);
    assign cache_ld    = (state == S_PAGE) && mg_ack && !mg_err;
    assign poll_clr    = (state == S_CMD) && mg_ack;
    assign poll_miss   = (state == S_POLL) && mg_ack && !mg_err && busy && !last_try;
    assign buf_ld      = (state == S_RDATA) && mg_ack && !mg_err;

    prs_page_cache #(.PAGE_W(8), .RESET_PAGE(8'hFF)) u_cache (
        .clk      (clk),
        .rst      (rst),
        .ld       (cache_ld),
        .ld_page  (rq.page),
        .cur_page (cur_page)
    );

    prs_poll_ctrl #(.MAX_POLLS(MAX_POLLS), .DLY_W(DLY_W)) u_poll (
        .clk       (clk),
        .rst       (rst),
        .clr       (poll_clr),
        .miss      (poll_miss),
        .gap       (poll_gap),
        .last_try  (last_try),
        .wait_over (wait_over)
    );

    prs_word_buf #(.NWORDS(4)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .ld    (buf_ld),
        .idx   (idx),
        .word  (mg_rdata),
        .width (rq.width),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            rq    <= '0;
            idx   <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                S_IDLE: if (req_valid) begin
                    rq.page  <= req_page;
                    rq.offs  <= req_offs;
                    rq.width <= width_e'(req_width);
                    rq.write <= req_write;
                    rq.wdata <= req_wdata;
                    idx      <= '0;
                    if (req_write)        state <= S_WDATA;
                    else if (page_new_in) state <= S_PAGE;
                    else                  state <= S_CMD;
                end
                S_WDATA: if (mg_ack) begin
                    if (mg_err) begin
                        done <= 1'b1; err <= 1'b1; state <= S_IDLE;
                    end else if (last_word) begin
                        idx   <= '0;
                        state <= page_new_q ? S_PAGE : S_CMD;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_PAGE: if (mg_ack) begin
                    if (mg_err) begin
                        done <= 1'b1; err <= 1'b1; state <= S_IDLE;
                    end else begin
                        state <= S_CMD;
                    end
                end
                S_CMD: if (mg_ack) begin
                    if (mg_err) begin
                        done <= 1'b1; err <= 1'b1; state <= S_IDLE;
                    end else begin
                        state <= S_POLL;
                    end
                end
                S_POLL: if (mg_ack) begin
                    if (mg_err) begin
                        done <= 1'b1; err <= 1'b1; state <= S_IDLE;
                    end else if (!busy) begin
                        idx <= '0;
                        if (rq.write) begin
                            done <= 1'b1; state <= S_IDLE;
                        end else begin
                            state <= S_RDATA;
                        end
                    end else if (last_try) begin
                        done <= 1'b1; err <= 1'b1; state <= S_IDLE;
                    end else begin
                        state <= S_WAIT;
                    end
                end
                S_WAIT: if (wait_over) state <= S_POLL;
                S_RDATA: if (mg_ack) begin
                    if (mg_err) begin
                        done <= 1'b1; err <= 1'b1; state <= S_IDLE;
                    end else if (last_word) begin
                        done <= 1'b1; state <= S_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state == S_IDLE);
        mg_phy    = 5'(PHY_ADDR);
        mg_req    = 1'b0;
        mg_we     = 1'b0;
        mg_reg    = '0;
        mg_wdata  = '0;
        case (state)
            S_WDATA: begin
                mg_req   = 1'b1;
                mg_we    = 1'b1;
                mg_reg   = MREG_DATA0 + {3'b000, idx};
                mg_wdata = pick_word(rq.wdata, idx, rq.width);
            end
            S_PAGE: begin
                mg_req   = 1'b1;
                mg_we    = 1'b1;
                mg_reg   = MREG_PAGE;
                mg_wdata = {rq.page, 7'b0, 1'b1};
            end
            S_CMD: begin
                mg_req   = 1'b1;
                mg_we    = 1'b1;
                mg_reg   = MREG_CMD;
                mg_wdata = {rq.offs, 6'b0, !rq.write, rq.write};
            end
            S_POLL: begin
                mg_req = 1'b1;
                mg_reg = MREG_CMD;
            end
            S_RDATA: begin
                mg_req = 1'b1;
                mg_reg = MREG_DATA0 + {3'b000, idx};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
    parameter int PHY_ADDR = 30
) (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        done,
    input logic        err,
    input logic        mg_req,
    input logic        mg_we,
    input logic [4:0]  mg_phy,
    input logic [4:0]  mg_reg,
    input logic [15:0] mg_wdata,
    input logic        mg_ack,
    input logic        mg_err
);
    assert_phy_fixed_R1: assert property (@(posedge clk) disable iff (rst)
        mg_req |-> mg_phy == 5'(PHY_ADDR));

    assert_page_enable_R2: assert property (@(posedge clk) disable iff (rst)
        (mg_req && mg_we && mg_reg == 5'h10) |-> mg_wdata[0]);

    assert_cmd_one_op_R3: assert property (@(posedge clk) disable iff (rst)
        (mg_req && mg_we && mg_reg == 5'h11) |-> $countones(mg_wdata[1:0]) == 1);

    assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
        (mg_req && mg_ack && mg_err) |=> (done && err && !mg_req));

    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_ready_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && mg_req));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mg_req && !mg_ack) |=> (mg_req && $stable(mg_reg) && $stable(mg_we) && $stable(mg_wdata)));
endmodule

bind paged_reg_seq prs_checker #(.PHY_ADDR(PHY_ADDR)) u_prs_checker (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .done      (done),
    .err       (err),
    .mg_req    (mg_req),
    .mg_we     (mg_we),
    .mg_phy    (mg_phy),
    .mg_reg    (mg_reg),
    .mg_wdata  (mg_wdata),
    .mg_ack    (mg_ack),
    .mg_err    (mg_err)
);

// File: tb/sim_paged_reg_seq.sv
`timescale 1ns/1ps
module sim_paged_reg_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_page = '0;
    logic [7:0]  req_offs = '0;
    logic [2:0]  req_width = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [15:0] poll_gap = '0;
    logic        done, err;
    logic [63:0] rdata;
    logic        mg_req, mg_we;
    logic [4:0]  mg_phy, mg_reg;
    logic [15:0] mg_wdata;
    logic        mg_ack = 1'b0;
    logic [15:0] mg_rdata = '0;
    logic        mg_err = 1'b0;

    always #2.5 clk = ~clk;

    paged_reg_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_page(req_page), .req_offs(req_offs), .req_width(req_width),
        .req_write(req_write), .req_wdata(req_wdata), .poll_gap(poll_gap),
        .done(done), .err(err), .rdata(rdata),
        .mg_req(mg_req), .mg_we(mg_we), .mg_phy(mg_phy), .mg_reg(mg_reg),
        .mg_wdata(mg_wdata), .mg_ack(mg_ack), .mg_rdata(mg_rdata), .mg_err(mg_err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // downstream model state
    logic [15:0] dreg [4];
    logic [7:0]  shadow_page = 8'hFF;
    logic [15:0] cmd_val, pg_val;
    logic [15:0] snap [4];
    int busy_cfg, busy_left, err_at, txn, lat;
    int pg_wr, cmd_wr, polls, dw, dr, phy_bad, dw_at_page, dw_at_cmd;
    int gap, min_gap;
    bit meas;

    task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic int nwords(logic [2:0] w);
        case (w)
            3'd0, 3'd1: return 1;
            3'd2:       return 2;
            3'd3:       return 3;
            default:    return 4;
        endcase
    endfunction

    function automatic logic [15:0] word_of(logic [63:0] d, int i, logic [2:0] w);
        logic [15:0] x;
        x = d[16*i +: 16];
        if (w == 3'd0) x[15:8] = 8'h00;
        return x;
    endfunction

    // downstream responder
    initial begin
        lat = 0;
        forever begin
            @(negedge clk);
            if (meas && !mg_req) gap++;
            if (mg_ack) begin
                mg_ack = 1'b0;
                mg_err = 1'b0;
            end else if (mg_req) begin
                if (meas) begin
                    if (gap < min_gap) min_gap = gap;
                    meas = 0;
                end
                if (lat > 0) lat--;
                else begin
                    bit e;
                    txn++;
                    e = (txn == err_at);
                    if (mg_phy != 5'd30) phy_bad++;
                    mg_rdata = '0;
                    if (mg_we) begin
                        if (mg_reg == 5'h10) begin
                            pg_wr++; pg_val = mg_wdata; dw_at_page = dw;
                            if (!e) shadow_page = mg_wdata[15:8];
                        end else if (mg_reg == 5'h11) begin
                            cmd_wr++; cmd_val = mg_wdata; busy_left = busy_cfg;
                            dw_at_cmd = dw;
                            for (int i = 0; i < 4; i++) snap[i] = dreg[i];
                        end else if (mg_reg >= 5'h18 && mg_reg <= 5'h1B) begin
                            dreg[mg_reg - 5'h18] = mg_wdata; dw++;
                        end
                    end else begin
                        if (mg_reg == 5'h11) begin
                            polls++;
                            if (busy_left > 0) begin
                                mg_rdata = cmd_val;
                                busy_left--;
                                if (!e) begin meas = 1; gap = 0; end
                            end else mg_rdata = cmd_val & 16'hFFFC;
                        end else if (mg_reg >= 5'h18 && mg_reg <= 5'h1B) begin
                            mg_rdata = dreg[mg_reg - 5'h18]; dr++;
                        end
                    end
                    mg_err = e;
                    mg_ack = 1'b1;
                    lat = $urandom % 3;
                end
            end
        end
    end

    task automatic run(logic [7:0] page, logic [7:0] offs, logic [2:0] w, bit we,
                       logic [63:0] wd, int busy, int dly, int eat, string tag);
        int n, exp_txn, to;
        bit exp_pg, got_err;
        logic [63:0] got_rd, exp_rd;
        n = nwords(w);
        exp_pg = (page != shadow_page);
        busy_cfg = busy; err_at = eat; txn = 0;
        pg_wr = 0; cmd_wr = 0; polls = 0; dw = 0; dr = 0; phy_bad = 0;
        dw_at_page = -1; dw_at_cmd = -1; min_gap = 1000; meas = 0;
        for (int i = 0; i < 4; i++) dreg[i] = 16'($urandom);
        while (!req_ready) @(negedge clk);
        req_page = page; req_offs = offs; req_width = w; req_write = we;
        req_wdata = wd; poll_gap = 16'(dly); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        to = 0;
        while (!done && to < 2000) begin @(negedge clk); to++; end
        got_err = err; got_rd = rdata;
        repeat (4) @(negedge clk);
        chk(phy_bad == 0, "R1", {tag, " phy address"}, 64'(phy_bad), 0);
        if (eat != 0) begin
            chk(got_err == 1'b1, "R9", {tag, " error flag"}, 64'(got_err), 1);
            chk(txn == eat, "R9", {tag, " transactions after error"}, 64'(txn), 64'(eat));
        end else if (busy >= 5) begin
            chk(got_err == 1'b1, "R6", {tag, " timeout error"}, 64'(got_err), 1);
            chk(polls == 5, "R6", {tag, " poll reads"}, 64'(polls), 5);
            chk(dr == 0, "R6", {tag, " no data read"}, 64'(dr), 0);
        end else begin
            exp_txn = (we ? n : 0) + int'(exp_pg) + 1 + (busy + 1) + (we ? 0 : n);
            chk(got_err == 1'b0, "R6", {tag, " no error"}, 64'(got_err), 0);
            chk(txn == exp_txn, "R4", {tag, " transaction count"}, 64'(txn), 64'(exp_txn));
            chk(pg_wr == int'(exp_pg), "R2", {tag, " page write"}, 64'(pg_wr), 64'(exp_pg));
            if (exp_pg)
                chk(pg_val == {page, 8'h01}, "R2", {tag, " page value"}, 64'(pg_val), 64'({page, 8'h01}));
            chk(cmd_val == {offs, 6'b0, !we, we}, "R3", {tag, " command value"},
                64'(cmd_val), 64'({offs, 6'b0, !we, we}));
            chk(polls == busy + 1, "R6", {tag, " poll count"}, 64'(polls), 64'(busy + 1));
            if (busy > 0)
                chk(min_gap >= dly, "R7", {tag, " poll gap"}, 64'(min_gap), 64'(dly));
            if (we) begin
                for (int i = 0; i < n; i++)
                    chk(snap[i] == word_of(wd, i, w), "R4", {tag, " data word"},
                        64'(snap[i]), 64'(word_of(wd, i, w)));
                chk(dw_at_cmd == n, "R5", {tag, " data before command"}, 64'(dw_at_cmd), 64'(n));
                if (exp_pg)
                    chk(dw_at_page == n, "R5", {tag, " data before page"}, 64'(dw_at_page), 64'(n));
            end else begin
                exp_rd = '0;
                for (int i = 0; i < n; i++) exp_rd[16*i +: 16] = dreg[i];
                if (w == 3'd0) exp_rd = exp_rd & 64'hFF;
                chk(got_rd == exp_rd, "R8", {tag, " read data"}, got_rd, exp_rd);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) dreg[i] = '0;
        void'($urandom(32'd7331));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after reset", 64'(req_ready), 1);
        chk(done == 1'b0 && mg_req == 1'b0, "R10", "quiet after reset", 64'({done, mg_req}), 0);

        // first request: cache starts at 0xFF so page 2 is written
        run(8'h02, 8'h34, 3'd1, 1'b0, '0, 0, 0, 0, "first read");
        run(8'h02, 8'h10, 3'd4, 1'b1, 64'h1122_3344_5566_7788, 2, 3, 0, "same page 64b write");
        run(8'h05, 8'h20, 3'd0, 1'b1, 64'hFFFF_FFFF_FFFF_ABCD, 0, 0, 0, "8b write");
        run(8'h05, 8'h21, 3'd0, 1'b0, '0, 1, 2, 0, "8b read");
        run(8'h05, 8'h22, 3'd3, 1'b0, '0, 4, 5, 0, "48b read four busy");
        run(8'h06, 8'h30, 3'd2, 1'b0, '0, 5, 1, 0, "timeout");
        run(8'h07, 8'h40, 3'd1, 1'b0, '0, 0, 0, 1, "page write error");
        run(8'h07, 8'h40, 3'd1, 1'b0, '0, 0, 0, 0, "page rewritten after error");
        run(8'h07, 8'h41, 3'd2, 1'b1, 64'h0, 0, 0, 2, "data write error");
        run(8'h07, 8'h42, 3'd1, 1'b0, '0, 1, 0, 3, "poll error");
        run(8'h07, 8'h43, 3'd4, 1'b0, '0, 0, 0, 4, "data read error");

        for (int k = 0; k < 60; k++) begin
            run(8'($urandom % 3 + 1), 8'($urandom), 3'($urandom % 5), 1'($urandom),
                {$urandom, $urandom}, $urandom % 5, $urandom % 4, 0, "random");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule